// File: doc/BRIEF.md
# Crossroad Traffic Light Sequencer

The block sequences the lamps of a four-way crossing with two approach directions, east-west and north-south. Each direction drives a red, a yellow and a green lamp. Each direction also has its own packed-BCD countdown that tells road users how long the current colour lasts. The sequencer walks a fixed four-phase cycle and advances only on clock edges where a one-second tick enable is high. At every phase boundary it reloads both countdowns with the durations of the phase being entered. Because of this, a red countdown always equals the green plus yellow time still to run in the opposing direction.

An emergency request overrides the cycle. While the request is high, both directions show red and both countdowns freeze. When the request is released, the cycle continues from the phase and counts it had reached. A synchronous reset returns the block to its starting phase. The lamp durations and the number of display digits are parameters; the defaults are red 45 s, green 40 s and yellow 5 s on two digits.

Top module: `tl_crossing`

## Requirements
- R1: The lamp vector is ordered {EW red, EW yellow, EW green, NS red, NS yellow, NS green} (bit 5 down to bit 0). The four phases show 6'h21, 6'h22, 6'h0C and 6'h14 respectively.
- R2: The phases run in a fixed order, wrapping back to the first:
  - EW red / NS green
  - EW red / NS yellow
  - EW green / NS red
  - EW yellow / NS red

  With a tick on every clock, one full cycle takes 90 ticks.
- R3: On a clock edge with reset high, the block enters the EW red / NS green phase with the EW count at 45 and the NS count at 40. This holds whatever the tick and emergency inputs are doing.
- R4: Each count is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. On each accepted tick that is not a phase boundary, both counts drop by one, with a correct borrow from the tens digit (8'h40 becomes 8'h39).
- R5: A phase ends on the accepted tick at which the count of the direction showing green or yellow is 1. On that tick both counts are reloaded for the next phase:
  - 5 and 5 when entering a yellow phase
  - EW 40 and NS 45 when entering EW green
  - EW 45 and NS 40 when entering NS green
- R6: The count of the direction showing red always equals the opposing direction's remaining green-plus-yellow time. In the two NS-active phases, EW equals NS + 5 during green and EW equals NS during yellow. The two EW-active phases mirror this.
- R7: While the emergency input is high, the lamp output is 6'h24 (both red) and both counts and the phase hold. After release, counting resumes from the held values.
- R8: On clock edges with the tick input low, the lamps, the phase and both counts do not change.
- R9: Exactly one lamp per direction is lit at all times, and the two green lamps are never lit together. Outside emergency, a green lamp always goes out to yellow and never straight to red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second advance enable |
| emerg | input | 1 | Emergency request, forces all red and freezes the counts |
| lamps | output | 6 | {EW red, EW yellow, EW green, NS red, NS yellow, NS green} |
| ew_count | output | 8 | East-west countdown, packed BCD |
| ns_count | output | 8 | North-south countdown, packed BCD |

## Verification
A tick on every clock drives the sequencer through complete cycles. This separates the phase order, the reload values at each boundary and the tens-digit borrow. Directed checks land on the last second of a green, the first second of a yellow and the first second of a crossing green. Stretches with the tick low show that nothing moves without an enable. Emergency bursts placed mid-phase show that lamps are forced red and counts freeze rather than being reloaded. Random mixes of sparse ticks, emergency bursts and occasional resets, compared against a bench model, expose any coupling between these three controls.

// File: rtl/tl_pkg.sv
package tl_pkg;

   typedef enum logic [1:0] {
      PH_EWR_NSG = 2'd0,
      PH_EWR_NSY = 2'd1,
      PH_EWG_NSR = 2'd2,
      PH_EWY_NSR = 2'd3
   } phase_t;

   localparam int LAMP_W = 6;
   localparam int MAX_DIG = 8;
   localparam logic [LAMP_W-1:0] LAMPS_ALL_RED = 6'b100_100;

   // bit order {EW r, EW y, EW g, NS r, NS y, NS g}
   function automatic logic [LAMP_W-1:0] phase_lamps(input phase_t p);
      logic [LAMP_W-1:0] l;
      case (p)
         PH_EWR_NSG: l = 6'b100_001;
         PH_EWR_NSY: l = 6'b100_010;
         PH_EWG_NSR: l = 6'b001_100;
         default:    l = 6'b010_100;
      endcase
      return l;
   endfunction

   function automatic logic [31:0] int_to_bcd(input int value, input int ndig);
      logic [31:0] r;
      int v;
      r = '0;
      v = value;
      for (int i = 0; i < MAX_DIG; i++) begin
         if (i < ndig) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
         end
      end
      return r;
   endfunction

   function automatic int bcd_to_int(input logic [31:0] b, input int ndig);
      int r;
      int m;
      r = 0;
      m = 1;
      for (int i = 0; i < MAX_DIG; i++) begin
         if (i < ndig) begin
            r += int'(b[4*i +: 4]) * m;
            m *= 10;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/tl_bcd_down.sv
module tl_bcd_down
   import tl_pkg::*;
#(
   parameter int NDIG    = 2,
   parameter int RST_VAL = 45
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              dec,
   input  logic [4*NDIG-1:0] load_val,
   output logic [4*NDIG-1:0] count,
   output logic              is_one
);

   localparam int W = 4 * NDIG;
   localparam logic [31:0] RST_FULL = int_to_bcd(RST_VAL, NDIG);
   localparam logic [W-1:0] RST_BCD = RST_FULL[W-1:0];

   logic [W-1:0] cnt_q;
   logic [W-1:0] dec_val;
   logic [NDIG-1:0] borrow_in;

   generate
      for (genvar i = 0; i < NDIG; i++) begin : g_dig
         logic [3:0] d;
         assign d = cnt_q[4*i +: 4];
         if (i == 0) begin : g_lsd
            assign borrow_in[i] = 1'b1;
         end else begin : g_upper
            assign borrow_in[i] = (cnt_q[4*i-1:0] == '0);
         end
         assign dec_val[4*i +: 4] = !borrow_in[i] ? d :
                                    (d == 4'd0)   ? 4'd9 : d - 4'd1;

         AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
            cnt_q[4*i +: 4] <= 4'd9);  // R4
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= RST_BCD;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= dec_val;
   end

   assign count  = cnt_q;
   assign is_one = (cnt_q == W'(1));

   AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
      ($past(dec) && !$past(load) && !$past(rst)) |->
      (bcd_to_int(32'(cnt_q), NDIG) == bcd_to_int(32'($past(cnt_q)), NDIG) - 1));  // R4

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!$past(dec) && !$past(load) && !$past(rst)) |-> (cnt_q == $past(cnt_q)));  // R8

endmodule

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
   import tl_pkg::*;
#(
   parameter int NDIG    = 2,
   parameter int RED_SEC = 45,
   parameter int GRN_SEC = 40,
   parameter int YEL_SEC = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              emerg,
   input  logic              ew_one,
   input  logic              ns_one,
   output phase_t            phase,
   output logic              load,
   output logic              dec,
   output logic [4*NDIG-1:0] ew_ld,
   output logic [4*NDIG-1:0] ns_ld
);

   localparam int CW = 4 * NDIG;
   localparam logic [31:0] RED_F = int_to_bcd(RED_SEC, NDIG);
   localparam logic [31:0] GRN_F = int_to_bcd(GRN_SEC, NDIG);
   localparam logic [31:0] YEL_F = int_to_bcd(YEL_SEC, NDIG);
   localparam logic [CW-1:0] RED_B = RED_F[CW-1:0];
   localparam logic [CW-1:0] GRN_B = GRN_F[CW-1:0];
   localparam logic [CW-1:0] YEL_B = YEL_F[CW-1:0];

   phase_t ph_q;
   phase_t ph_nx;
   logic   adv;
   logic   expire;

   assign adv    = tick && !emerg;
   assign expire = (ph_q == PH_EWR_NSG || ph_q == PH_EWR_NSY) ? ns_one : ew_one;
   assign load   = adv && expire;
   assign dec    = adv && !expire;
   assign ph_nx  = phase_t'(2'(ph_q + 2'd1));

   always_comb begin
      case (ph_nx)
         PH_EWR_NSY, PH_EWY_NSR: begin
            ew_ld = YEL_B;
            ns_ld = YEL_B;
         end
         PH_EWG_NSR: begin
            ew_ld = GRN_B;
            ns_ld = RED_B;
         end
         default: begin
            ew_ld = RED_B;
            ns_ld = GRN_B;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)       ph_q <= PH_EWR_NSG;
      else if (load) ph_q <= ph_nx;
   end

   assign phase = ph_q;

   AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
      $past(rst) || (ph_q == $past(ph_q)) ||
      (ph_q == phase_t'(2'($past(ph_q) + 2'd1))));  // R2

   AST_PHASE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (ph_q != $past(ph_q))) |-> ($past(tick) && !$past(emerg)));  // R8

endmodule

// File: rtl/tl_crossing.sv
module tl_crossing
   import tl_pkg::*;
#(
   parameter int NDIG    = 2,
   parameter int RED_SEC = 45,
   parameter int GRN_SEC = 40,
   parameter int YEL_SEC = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              emerg,
   output logic [5:0]        lamps,
   output logic [4*NDIG-1:0] ew_count,
   output logic [4*NDIG-1:0] ns_count
);

   localparam int CW   = 4 * NDIG;
   localparam int NDIR = 2;

   if (NDIG < 1 || NDIG > MAX_DIG) begin : g_bad_ndig
      $error("tl_crossing: NDIG must be 1..8");
   end
   if (RED_SEC != GRN_SEC + YEL_SEC) begin : g_bad_sum
      $error("tl_crossing: red time must equal green plus yellow");
   end
   if (GRN_SEC < 1 || YEL_SEC < 1) begin : g_bad_min
      $error("tl_crossing: green and yellow must be at least one second");
   end
   if (RED_SEC >= 10 ** NDIG) begin : g_bad_fit
      $error("tl_crossing: red time does not fit the digit count");
   end

   phase_t          phase;
   logic            load;
   logic            dec;
   logic [CW-1:0]   ld_val [NDIR];
   logic [CW-1:0]   cnt    [NDIR];
   logic [NDIR-1:0] one;

   tl_phase_seq #(
      .NDIG(NDIG), .RED_SEC(RED_SEC), .GRN_SEC(GRN_SEC), .YEL_SEC(YEL_SEC)
   ) u_seq (
      .clk(clk), .rst(rst), .tick(tick), .emerg(emerg),
      .ew_one(one[0]), .ns_one(one[1]),
      .phase(phase), .load(load), .dec(dec),
      .ew_ld(ld_val[0]), .ns_ld(ld_val[1])
   );

   // direction 0 = east-west (starts red), 1 = north-south (starts green)
   generate
      for (genvar d = 0; d < NDIR; d++) begin : g_dir
         tl_bcd_down #(
            .NDIG(NDIG), .RST_VAL((d == 0) ? RED_SEC : GRN_SEC)
         ) u_cnt (
            .clk(clk), .rst(rst), .load(load), .dec(dec),
            .load_val(ld_val[d]), .count(cnt[d]), .is_one(one[d])
         );
      end
   endgenerate

   assign ew_count = cnt[0];
   assign ns_count = cnt[1];
   assign lamps    = emerg ? LAMPS_ALL_RED : phase_lamps(phase);

   AST_ONE_LAMP_EW: assert property (@(posedge clk) disable iff (rst)
      $countones(lamps[5:3]) == 1);  // R9
   AST_ONE_LAMP_NS: assert property (@(posedge clk) disable iff (rst)
      $countones(lamps[2:0]) == 1);  // R9
   AST_NO_DUAL_GREEN: assert property (@(posedge clk) disable iff (rst)
      !(lamps[3] && lamps[0]));  // R9
   AST_EW_GREEN_TO_YELLOW: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !emerg && !$past(emerg) && $past(lamps[3]) && !lamps[3]) |-> lamps[4]);  // R9
   AST_NS_GREEN_TO_YELLOW: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !emerg && !$past(emerg) && $past(lamps[0]) && !lamps[0]) |-> lamps[1]);  // R9
   AST_RED_SUM_NSG: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EWR_NSG) |->
      (bcd_to_int(32'(cnt[0]), NDIG) == bcd_to_int(32'(cnt[1]), NDIG) + YEL_SEC));  // R6
   AST_RED_SUM_EWG: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EWG_NSR) |->
      (bcd_to_int(32'(cnt[1]), NDIG) == bcd_to_int(32'(cnt[0]), NDIG) + YEL_SEC));  // R6
   AST_RED_SUM_YEL: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EWR_NSY || phase == PH_EWY_NSR) |-> (cnt[0] == cnt[1]));  // R6
   AST_EMERG_FREEZE: assert property (@(posedge clk) disable iff (rst)
      ($past(emerg) && !$past(rst)) |->
      (cnt[0] == $past(cnt[0]) && cnt[1] == $past(cnt[1]) && phase == $past(phase)));  // R7

endmodule

// File: tb/sim_tl_crossing.sv
module sim_tl_crossing;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic       emerg = 1'b0;
   logic [5:0] lamps;
   logic [7:0] ew_count;
   logic [7:0] ns_count;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench model
   int m_ph = 0;
   int m_ew = 45;
   int m_ns = 40;

   always #2.5 clk = ~clk;

   tl_crossing u0 (
      .clk(clk), .rst(rst), .tick(tick), .emerg(emerg),
      .lamps(lamps), .ew_count(ew_count), .ns_count(ns_count)
   );

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic logic [5:0] lamps_for(input int ph, input bit e);
      if (e) return 6'h24;
      case (ph)
         0:       return 6'h21;
         1:       return 6'h22;
         2:       return 6'h0C;
         default: return 6'h14;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step(input bit r, input bit t, input bit e);
      bit expire;
      if (r) begin
         m_ph = 0; m_ew = 45; m_ns = 40;
      end else if (t && !e) begin
         expire = (m_ph < 2) ? (m_ns == 1) : (m_ew == 1);
         if (expire) begin
            m_ph = (m_ph + 1) % 4;
            case (m_ph)
               1, 3:    begin m_ew = 5;  m_ns = 5;  end
               2:       begin m_ew = 40; m_ns = 45; end
               default: begin m_ew = 45; m_ns = 40; end
            endcase
         end else begin
            m_ew--; m_ns--;
         end
      end
   endtask

   // one clock: drive, let the edge pass, sample at the falling edge
   task automatic cyc(input bit r, input bit t, input bit e, input string tag);
      rst = r; tick = t; emerg = e;
      @(posedge clk);
      model_step(r, t, e);
      @(negedge clk);
      check({tag, " lamps"}, {2'b00, lamps}, {2'b00, lamps_for(m_ph, e)});
      check({tag, " ew"}, ew_count, to_bcd(m_ew));
      check({tag, " ns"}, ns_count, to_bcd(m_ns));
      check("R9 dual green", {7'd0, lamps[3] & lamps[0]}, 8'd0);
   endtask

   initial begin
      int em_left;
      void'($urandom(32'd20250611));
      @(negedge clk);
      cyc(1, 0, 0, "R3 reset");
      cyc(1, 1, 1, "R3 reset with tick and emergency");
      cyc(0, 0, 0, "R8 idle");
      cyc(0, 0, 0, "R8 idle");

      // two full cycles with a tick every clock
      for (int k = 1; k <= 180; k++) begin
         cyc(0, 1, 0, "R2 full cycle");
         if (k == 1) check("R4 borrow 40 to 39", ns_count, 8'h39);
         if (k == 39) begin
            check("R5 last green second ns", ns_count, 8'h01);
            check("R5 last green second ew", ew_count, 8'h06);
         end
         if (k == 40) begin
            check("R5 yellow reload ew", ew_count, 8'h05);
            check("R1 ns yellow lamps", {2'b00, lamps}, 8'h22);
         end
         if (k == 45) begin
            check("R6 ew green reload", ew_count, 8'h40);
            check("R6 ns red reload", ns_count, 8'h45);
            check("R1 ew green lamps", {2'b00, lamps}, 8'h0C);
         end
         if (k == 85) check("R1 ew yellow lamps", {2'b00, lamps}, 8'h14);
         if (k == 90) begin
            check("R2 cycle wraps ew", ew_count, 8'h45);
            check("R2 cycle wraps ns", ns_count, 8'h40);
            check("R2 cycle wraps lamps", {2'b00, lamps}, 8'h21);
         end
      end

      // advance into the EW green phase, then hold an emergency
      for (int k = 0; k < 50; k++) cyc(0, 1, 0, "R2 advance");
      for (int k = 0; k < 10; k++) cyc(0, 1, 1, "R7 emergency hold");
      check("R7 all red", {2'b00, lamps}, 8'h24);
      for (int k = 0; k < 5; k++) cyc(0, 1, 0, "R7 resume");
      for (int k = 0; k < 6; k++) cyc(0, 0, 0, "R8 no tick");

      // mid-run reset
      cyc(1, 1, 0, "R3 mid-run reset");
      check("R3 ew after reset", ew_count, 8'h45);

      // random mix
      em_left = 0;
      for (int k = 0; k < 3000; k++) begin
         bit r, t, e;
         t = ($urandom % 3) != 0;
         if (em_left > 0) begin
            e = 1; em_left--;
         end else if ($urandom % 60 == 0) begin
            em_left = 1 + int'($urandom % 8); e = 1;
         end else begin
            e = 0;
         end
         r = ($urandom % 700) == 0;
         cyc(r, t, e, "R1 random mix");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #500us;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule